// File: doc/BRIEF.md
# Seven-Pin GPIO Port with Change-Detect Wake

This block controls a seven-pin general-purpose I/O port through four byte-wide registers on a simple synchronous bus. The registers hold the output latch, the pin directions, the pad mode and the per-pin change-detect enables. From these registers the block computes each pad's output-enable, output value and pull-up enable. Pull-up and drive type are set once for each of two pin groups: a low group (pins 0 to 3) and a high group (pins 4 to 6).

Each pin input passes through a two-flop synchroniser before the block uses it. A rising or a falling transition on a pin that is an input and has change detection enabled sets one shared port event flag. While the flag is set, it asserts the halt-release output when the global wake enable is high, and it asserts the interrupt request when the global interrupt enable is high. The flag is cleared by a one-cycle clear strobe.

The event logic is a state machine with five states:
- `EVT_ARM0`, `EVT_ARM1` and `EVT_ARM2` fill the synchroniser after reset. Edges are ignored in these states.
- `EVT_IDLE` is the state with no pending event.
- `EVT_PEND` is the state with the event flag set.

The transitions are:
- `arm_step`: ARM0 to ARM1 to ARM2, one per clock.
- `arm_done`: ARM2 to IDLE.
- `edge_hit`: IDLE to PEND on a qualifying edge.
- `pend_hold`: PEND stays in PEND when no clear is seen, or when a clear and a qualifying edge coincide.
- `sw_clear`: PEND to IDLE on a clear with no qualifying edge.

Top module: `gpio_wake_port`

## Requirements
- R1: After reset the direction, mode and enable registers read 0x00, `pad_oe` and `pad_pu` are all 0, and `irq_req` and `halt_release` are 0.
- R2: The registers decode at offsets 0 to 3 from `BASE_ADDR` (default 0xEC), in this order: data latch, direction, mode, change enable. Bit 7 of every register reads 0 and ignores writes. Mode bits other than 0, 1, 4 and 5 read 0 and ignore writes.
- R3: A direction bit of 1 makes its pin an output and 0 makes it an input. An input pin always has `pad_oe` at 0. A push-pull output pin has `pad_oe` at 1 and `pad_do` equal to its latch bit.
- R4: Mode bit 1 selects open-drain for pins 0 to 3, and mode bit 5 selects it for pins 4 to 6 (1 is open-drain, 0 is push-pull). An open-drain output pin has `pad_do` at 0 and `pad_oe` equal to the inverse of its latch bit.
- R5: Mode bit 0 drives `pad_pu` for pins 0 to 3, and mode bit 4 drives it for pins 4 to 6. This holds whatever the pin direction is.
- R6: A read of the data register returns the latch bit for output pins and the synchronised pin level for input pins. An input change becomes visible in the read data after two rising clock edges.
- R7: A rising or falling change on a pin that is an input and has its enable bit set sets the event flag at the third rising edge after the change.
- R8: A change on a pin that is an output, or that has its enable bit at 0, leaves the event flag unchanged.
- R9: `irq_req` is the event flag ANDed with `irq_en`, and `halt_release` is the event flag ANDed with `wake_en`.
- R10: The flag stays set until `evt_clr` is high at a clock edge. When a qualifying edge arrives in the same cycle as the clear, the flag stays set.
- R11: No event is raised during the first three clock edges after reset, whatever the pin levels are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| evt_clr | input | 1 | Clears the event flag (one-cycle strobe) |
| wake_en | input | 1 | Global halt-release enable |
| irq_en | input | 1 | Global interrupt enable |
| pin_in | input | 7 | Pad input levels (asynchronous) |
| pad_oe | output | 7 | Pad output-enable, one bit per pin |
| pad_do | output | 7 | Pad output value, one bit per pin |
| pad_pu | output | 7 | Pad pull-up enable, one bit per pin |
| halt_release | output | 1 | Halt-release request |
| irq_req | output | 1 | Interrupt request |

## Verification
The assertions assume that `irq_en` and `wake_en` are the only routes to the request outputs. They also assume that pin changes may arrive at any time, which is why the post-reset arming window is checked with a cycle counter rather than a pin-level precondition.

The stimulus changes pins only on falling clock edges and holds each level for several cycles, so every change passes cleanly through the synchroniser. Each clear strobe lasts exactly one cycle. The coincident clear-and-edge case is placed deliberately on the cycle in which the synchronised edge reaches the detector.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;

    // Event flag life cycle: three arming states fill the synchroniser
    typedef enum logic [2:0] {
        EVT_ARM0 = 3'd0,
        EVT_ARM1 = 3'd1,
        EVT_ARM2 = 3'd2,
        EVT_IDLE = 3'd3,
        EVT_PEND = 3'd4
    } evt_state_e;

    // Stored mode bits, one pair per pin group
    typedef struct packed {
        logic od_hi;
        logic pu_hi;
        logic od_lo;
        logic pu_lo;
    } pad_mode_t;

    // Mode register bit positions
    localparam int MODE_PU_LO = 0;
    localparam int MODE_OD_LO = 1;
    localparam int MODE_PU_HI = 4;
    localparam int MODE_OD_HI = 5;

    // Register offsets from the base address
    localparam logic [7:0] OFF_DATA = 8'd0;
    localparam logic [7:0] OFF_DIR  = 8'd1;
    localparam logic [7:0] OFF_MODE = 8'd2;
    localparam logic [7:0] OFF_IEN  = 8'd3;

endpackage

// File: rtl/gpio_wake_regs.sv
module gpio_wake_regs
    import gpio_wake_pkg::*;
#(
    parameter int         PINS      = 7,
    parameter logic [7:0] BASE_ADDR = 8'hEC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [7:0]      bus_addr,
    input  logic [7:0]      bus_wdata,
    input  logic [PINS-1:0] pin_level,
    output logic [7:0]      bus_rdata,
    output logic [PINS-1:0] latch_q,
    output logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] ien_q,
    output pad_mode_t       mode_q
);

    logic [7:0]      offset;
    logic [PINS-1:0] data_view;
    logic            unused_wbits;

    assign offset       = bus_addr - BASE_ADDR;
    assign unused_wbits = ^bus_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
            ien_q   <= '0;
            mode_q  <= '0;
        end else if (bus_we) begin
            unique case (offset)
                OFF_DATA: latch_q <= bus_wdata[PINS-1:0];
                OFF_DIR:  dir_q   <= bus_wdata[PINS-1:0];
                OFF_IEN:  ien_q   <= bus_wdata[PINS-1:0];
                OFF_MODE: begin
                    mode_q.pu_lo <= bus_wdata[MODE_PU_LO];
                    mode_q.od_lo <= bus_wdata[MODE_OD_LO];
                    mode_q.pu_hi <= bus_wdata[MODE_PU_HI];
                    mode_q.od_hi <= bus_wdata[MODE_OD_HI];
                end
                default: ;
            endcase
        end
    end

    // Output pins show their latch, input pins their synchronised level
    always_comb begin
        for (int i = 0; i < PINS; i++) begin
            data_view[i] = dir_q[i] ? latch_q[i] : pin_level[i];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (offset)
            OFF_DATA: bus_rdata[PINS-1:0] = data_view;
            OFF_DIR:  bus_rdata[PINS-1:0] = dir_q;
            OFF_IEN:  bus_rdata[PINS-1:0] = ien_q;
            OFF_MODE: begin
                bus_rdata[MODE_PU_LO] = mode_q.pu_lo;
                bus_rdata[MODE_OD_LO] = mode_q.od_lo;
                bus_rdata[MODE_PU_HI] = mode_q.pu_hi;
                bus_rdata[MODE_OD_HI] = mode_q.od_hi;
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_wake_sync.sv
module gpio_wake_sync #(
    parameter int PINS = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pin_level,
    output logic [PINS-1:0] pin_chg
);

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        logic meta_q;
        logic sync_q;
        logic prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin_in[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign pin_level[g] = sync_q;
        assign pin_chg[g]   = sync_q ^ prev_q;
    end

endmodule

// File: rtl/gpio_wake_pad.sv
module gpio_wake_pad
    import gpio_wake_pkg::*;
#(
    parameter int PINS     = 7,
    parameter int LO_PINS  = 4
) (
    input  logic [PINS-1:0] latch_q,
    input  logic [PINS-1:0] dir_q,
    input  pad_mode_t       mode_q,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_do,
    output logic [PINS-1:0] pad_pu
);

    for (genvar g = 0; g < PINS; g++) begin : g_pad
        logic od_sel;
        logic pu_sel;

        if (g < LO_PINS) begin : g_lo
            assign od_sel = mode_q.od_lo;
            assign pu_sel = mode_q.pu_lo;
        end else begin : g_hi
            assign od_sel = mode_q.od_hi;
            assign pu_sel = mode_q.pu_hi;
        end

        // Open-drain only pulls low; a latch of 1 releases the pad
        assign pad_oe[g] = dir_q[g] & ~(od_sel & latch_q[g]);
        assign pad_do[g] = latch_q[g] & ~od_sel;
        assign pad_pu[g] = pu_sel;
    end

endmodule

// File: rtl/gpio_wake_evt.sv
module gpio_wake_evt
    import gpio_wake_pkg::*;
#(
    parameter int PINS = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_chg,
    input  logic [PINS-1:0] dir_q,
    input  logic [PINS-1:0] ien_q,
    input  logic            evt_clr,
    input  logic            wake_en,
    input  logic            irq_en,
    output logic            evt_pend,
    output logic            halt_release,
    output logic            irq_req
);

    evt_state_e state_q;
    evt_state_e state_d;
    logic       edge_hit;

    assign edge_hit = |(pin_chg & ~dir_q & ien_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EVT_ARM0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EVT_ARM0: state_d = EVT_ARM1;
            EVT_ARM1: state_d = EVT_ARM2;
            EVT_ARM2: state_d = EVT_IDLE;
            EVT_IDLE: if (edge_hit) state_d = EVT_PEND;
            EVT_PEND: if (evt_clr && !edge_hit) state_d = EVT_IDLE;
            default:  state_d = EVT_IDLE;
        endcase
    end

    always_comb begin
        evt_pend     = (state_q == EVT_PEND);
        halt_release = evt_pend & wake_en;
        irq_req      = evt_pend & irq_en;
    end

endmodule

// File: rtl/gpio_wake_port.sv
module gpio_wake_port
    import gpio_wake_pkg::*;
#(
    parameter int         PINS      = 7,
    parameter int         LO_PINS   = 4,
    parameter logic [7:0] BASE_ADDR = 8'hEC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [7:0]      bus_addr,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    input  logic            evt_clr,
    input  logic            wake_en,
    input  logic            irq_en,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_do,
    output logic [PINS-1:0] pad_pu,
    output logic            halt_release,
    output logic            irq_req
);

    logic [PINS-1:0] latch_q;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] ien_q;
    pad_mode_t       mode_q;
    logic [PINS-1:0] pin_level;
    logic [PINS-1:0] pin_chg;
    logic            evt_pend;

    gpio_wake_sync #(.PINS(PINS)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .pin_level (pin_level),
        .pin_chg   (pin_chg)
    );

    gpio_wake_regs #(.PINS(PINS), .BASE_ADDR(BASE_ADDR)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_level (pin_level),
        .bus_rdata (bus_rdata),
        .latch_q   (latch_q),
        .dir_q     (dir_q),
        .ien_q     (ien_q),
        .mode_q    (mode_q)
    );

    gpio_wake_pad #(.PINS(PINS), .LO_PINS(LO_PINS)) pad_i (
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .mode_q  (mode_q),
        .pad_oe  (pad_oe),
        .pad_do  (pad_do),
        .pad_pu  (pad_pu)
    );

    gpio_wake_evt #(.PINS(PINS)) evt_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_chg      (pin_chg),
        .dir_q        (dir_q),
        .ien_q        (ien_q),
        .evt_clr      (evt_clr),
        .wake_en      (wake_en),
        .irq_en       (irq_en),
        .evt_pend     (evt_pend),
        .halt_release (halt_release),
        .irq_req      (irq_req)
    );

endmodule

// File: rtl/gpio_wake_port_chk.sv
module gpio_wake_port_chk #(
    parameter int PINS = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic [7:0]      bus_rdata,
    input logic            evt_clr,
    input logic            wake_en,
    input logic            irq_en,
    input logic [PINS-1:0] dir_q,
    input logic [PINS-1:0] latch_q,
    input logic [PINS-1:0] pad_oe,
    input logic [PINS-1:0] pad_do,
    input logic            evt_pend,
    input logic            halt_release,
    input logic            irq_req
);

    logic [1:0] arm_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_cnt <= 2'd0;
        end else if (arm_cnt != 2'd3) begin
            arm_cnt <= arm_cnt + 2'd1;
        end
    end

    // R2
    rdata_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[7] == 1'b0);

    // R3
    input_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~dir_q) == '0);

    // R4
    drive_follows_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_do & ~latch_q) == '0);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_en && evt_pend));

    // R9
    halt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_release |-> (wake_en && evt_pend));

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pend && !evt_clr) |=> evt_pend);

    // R11
    arm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_cnt != 2'd3) |-> !evt_pend);

endmodule

bind gpio_wake_port gpio_wake_port_chk #(.PINS(PINS)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_rdata    (bus_rdata),
    .evt_clr      (evt_clr),
    .wake_en      (wake_en),
    .irq_en       (irq_en),
    .dir_q        (dir_q),
    .latch_q      (latch_q),
    .pad_oe       (pad_oe),
    .pad_do       (pad_do),
    .evt_pend     (evt_pend),
    .halt_release (halt_release),
    .irq_req      (irq_req)
);

// File: tb/gpio_wake_port_tb.sv
`timescale 1ns/1ps
module gpio_wake_port_tb_top;

    localparam logic [7:0] A_DATA = 8'hEC;
    localparam logic [7:0] A_DIR  = 8'hED;
    localparam logic [7:0] A_MODE = 8'hEE;
    localparam logic [7:0] A_IEN  = 8'hEF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       evt_clr = 1'b0;
    logic       wake_en = 1'b1;
    logic       irq_en = 1'b1;
    logic [6:0] pin_in = 7'h00;
    logic [6:0] pad_oe, pad_do, pad_pu;
    logic       halt_release, irq_req;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    gpio_wake_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_clr(evt_clr),
        .wake_en(wake_en), .irq_en(irq_en), .pin_in(pin_in),
        .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu),
        .halt_release(halt_release), .irq_req(irq_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        // R11: pins high through reset, enables set at once
        pin_in = 7'h7F;
        cycles(2);
        rst_n = 1'b1;
        wr(A_IEN, 8'h7F);
        cycles(6);
        check("R11 no event after reset", {30'd0, irq_req, halt_release}, 32'd0);
        rd(A_DIR, r);  check("R1 dir reset", r, 8'h00);
        rd(A_MODE, r); check("R1 mode reset", r, 8'h00);
        check("R1 pad_oe reset", pad_oe, 7'h00);
        check("R1 pad_pu reset", pad_pu, 7'h00);
        rd(A_DATA, r); check("R6 input level read", r, 8'h7F);
        rd(A_IEN, r);  check("R2 ien readback", r, 8'h7F);

        // R2: bit 7 and unused mode bits
        wr(A_DIR, 8'hFF);  rd(A_DIR, r);  check("R2 dir bit7", r, 8'h7F);
        wr(A_MODE, 8'hFF); rd(A_MODE, r); check("R2 mode mask", r, 8'h33);
        wr(A_MODE, 8'h00);
        rd(8'hF0, r); check("R2 out of range read", r, 8'h00);

        // R3 R4 R5: sweep of mode, latch and direction
        for (int m = 0; m < 16; m++) begin
            for (int li = 0; li < 4; li++) begin
                logic [6:0] lat, odm, pum;
                lat = (li == 0) ? 7'h00 : (li == 1) ? 7'h55 : (li == 2) ? 7'h2A : 7'h7F;
                odm = (m[1] ? 7'h0F : 7'h00) | (m[3] ? 7'h70 : 7'h00);
                pum = (m[0] ? 7'h0F : 7'h00) | (m[2] ? 7'h70 : 7'h00);
                wr(A_MODE, {2'b11, m[3], m[2], 2'b11, m[1], m[0]});
                wr(A_DATA, {1'b0, lat});
                for (int d = 0; d < 128; d++) begin
                    logic [6:0] dv;
                    dv = d[6:0];
                    wr(A_DIR, {1'b0, dv});
                    check("R3 R4 R5 pad sweep", {11'd0, pad_oe, pad_do, pad_pu},
                          {11'd0, dv & ~(odm & lat), lat & ~odm, pum});
                end
            end
        end
        wr(A_MODE, 8'h00);

        // R6: data read mixes latch and synchronised level
        pin_in = 7'h35;
        wr(A_DATA, 8'h4A);
        cycles(3);
        for (int d = 0; d < 128; d++) begin
            logic [6:0] dv;
            dv = d[6:0];
            wr(A_DIR, {1'b0, dv});
            rd(A_DATA, r);
            check("R6 data read", r, {1'b0, (dv & 7'h4A) | (~dv & 7'h35)});
        end
        wr(A_DIR, 8'h00);
        wr(A_DATA, 8'h00);
        cycles(4);
        evt_clr = 1'b1; cycles(1); evt_clr = 1'b0;
        check("R10 clear", irq_req, 1'b0);

        // R6 latency: change visible after two rising edges
        pin_in = 7'h36;
        @(posedge clk); #1 rd(A_DATA, r); check("R6 latency early", r, 8'h35);
        @(posedge clk); #1 rd(A_DATA, r); check("R6 latency", r, 8'h36);
        cycles(3);
        evt_clr = 1'b1; cycles(1); evt_clr = 1'b0;

        // R7: both edges on each pin, exact latency
        for (int p = 0; p < 7; p++) begin
            for (int e = 0; e < 2; e++) begin
                wr(A_IEN, 8'h01 << p);
                pin_in = pin_in ^ (7'h01 << p);
                @(posedge clk); @(posedge clk); #1;
                check("R7 not yet", irq_req, 1'b0);
                @(posedge clk); #1;
                check("R7 edge sets flag", {30'd0, irq_req, halt_release}, 32'd3);
                @(negedge clk);
                evt_clr = 1'b1; cycles(1); evt_clr = 1'b0;
                check("R10 clear", irq_req, 1'b0);
            end
        end

        // R8: disabled pin and output pin
        for (int p = 0; p < 7; p++) begin
            wr(A_IEN, {1'b0, ~(7'h01 << p)});
            pin_in = pin_in ^ (7'h01 << p);
            cycles(5);
            check("R8 disabled pin", irq_req, 1'b0);
            wr(A_IEN, 8'h7F);
            wr(A_DIR, 8'h01 << p);
            pin_in = pin_in ^ (7'h01 << p);
            cycles(5);
            check("R8 output pin", irq_req, 1'b0);
            wr(A_DIR, 8'h00);
            cycles(4);
            check("R8 direction change", irq_req, 1'b0);
        end

        // R9: gating of the two request outputs
        wr(A_IEN, 8'h7F);
        pin_in = pin_in ^ 7'h01;
        cycles(4);
        wake_en = 1'b0; irq_en = 1'b1; #1;
        check("R9 irq only", {30'd0, irq_req, halt_release}, 32'd2);
        wake_en = 1'b1; irq_en = 1'b0; #1;
        check("R9 halt only", {30'd0, irq_req, halt_release}, 32'd1);
        irq_en = 1'b1;

        // R10: hold without clear, then clear coinciding with an edge
        cycles(10);
        check("R10 hold", irq_req, 1'b1);
        pin_in = pin_in ^ 7'h02;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        evt_clr = 1'b1; cycles(1); evt_clr = 1'b0;
        check("R10 clear loses to edge", irq_req, 1'b1);
        evt_clr = 1'b1; cycles(1); evt_clr = 1'b0;
        check("R10 clear alone", irq_req, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule